// File: doc/BRIEF.md
# Stream Array Address Generator

This block sits beside a single scratch-memory port and turns compact load/store requests into memory addresses for array and vector streams. It keeps a small file of access descriptors ("contexts"). Each descriptor is one 32-bit word that names a base address, two shift amounts and two loop-counter slots. A request names one descriptor. The block picks the two loop-counter values that the descriptor points at, shifts each one by its own amount, ORs the results and adds the base. With row and element sizes that are powers of two, this gives the address of a row-major element.

A request can also swap the first counter for a small immediate unroll factor, which is useful for unrolled or software-pipelined loops. Or it can skip the computation and pass through an address that a neighbouring ALU computed. One counter slot always reads as zero, so vectors and pass-through accesses can leave out a loop variable. A descriptor can be rewritten in any cycle with no stall. The address is registered and appears one cycle after its request.

Top module: `sag_top`

## Requirements
- R1: While reset is asserted, and after reset until the first request, `addr_valid` is 0.
- R2: A descriptor written in one cycle takes effect for a request in the next cycle. A write completes in a single cycle.
- R3: The descriptor word layout is: base in bits [15:0], first shift in [19:16], second shift in [23:20], first counter slot in [26:24], second counter slot in [29:27]. The address is base + ((cntA << shiftA) | (cntB << shiftB)), and each shifted term is truncated to 16 bits.
- R4: Each of the four descriptors, selected by `req_ctx`, holds its own base, shifts and counter slots. Requests to different descriptors use their own fields.
- R5: Counter slot 7 always contributes zero, whatever value is driven on `loop_cnt[127:112]`.
- R6: When `req_use_unroll` is 1, the 4-bit `req_unroll` value, zero-extended, replaces cntA. cntB is still used.
- R7: When `req_use_alu` is 1, `addr_out` equals `req_alu_addr` and ignores the descriptor.
- R8: `addr_valid` equals the `req_valid` of the previous cycle. `addr_out` is valid in the same cycle and belongs to that request.
- R9: When a write and a request target the same descriptor in the same cycle, the request uses the descriptor's previous contents.
- R10: Bits [31:30] of a written word are ignored and never affect an address.
- R11: The final sum wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Descriptor write strobe |
| wr_idx | input | 2 | Descriptor to write |
| wr_word | input | 32 | Packed descriptor word |
| req_valid | input | 1 | Request present |
| req_ctx | input | 2 | Descriptor used by the request |
| req_unroll | input | 4 | Immediate unroll factor |
| req_use_unroll | input | 1 | Use the unroll factor in place of cntA |
| req_use_alu | input | 1 | Output req_alu_addr directly |
| req_alu_addr | input | 16 | Address computed by the ALU |
| loop_cnt | input | 128 | Eight 16-bit loop counters, slot k at bits [16k+15:16k] |
| addr_valid | output | 1 | Address output valid |
| addr_out | output | 16 | Generated address |

## Verification
Every cycle, the assertions check that `addr_valid` trails `req_valid` by exactly one cycle, that a pass-through request reproduces its ALU address, that a write lands in the addressed descriptor, that reserved descriptor bits stay zero, and that the zero slot gives a zero counter. The address arithmetic needs the bench's scenarios: field placement, per-descriptor counter selection, unroll substitution, modulo-2^16 wrap and the read-before-write ordering of a same-cycle write and request. The bench compares each result against a model that is built only from the descriptor layout.

// File: rtl/sag_pkg.sv
package sag_pkg;
   localparam int WORD_W  = 32;
   localparam int BASE_W  = 16;
   localparam int SHAMT_W = 4;
   localparam int SLOT_W  = 3;

   typedef struct packed {
      logic [1:0]         rsvd;
      logic [SLOT_W-1:0]  slot_b;
      logic [SLOT_W-1:0]  slot_a;
      logic [SHAMT_W-1:0] sh_b;
      logic [SHAMT_W-1:0] sh_a;
      logic [BASE_W-1:0]  base;
   } sag_ctx_t;
endpackage

// File: rtl/sag_ctx_rf.sv
module sag_ctx_rf
   import sag_pkg::*;
#(
   parameter int NUM_CTX = 4,
   localparam int IDX_W = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [IDX_W-1:0]  rd_idx,
   output sag_ctx_t          rd_ctx
);
   sag_ctx_t ctx_q [NUM_CTX];

   for (genvar e = 0; e < NUM_CTX; e++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctx_q[e] <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(e))) begin
            ctx_q[e]      <= sag_ctx_t'(wr_word);
            ctx_q[e].rsvd <= 2'b00;
         end
      end

      // R2: a write lands in the addressed entry by the next cycle
      p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (wr_en && wr_idx == IDX_W'(e)) |=> (ctx_q[e][29:0] == $past(wr_word[29:0])));

      // R10: reserved bits never held as ones
      p_rsvd_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
         ctx_q[e].rsvd == 2'b00);
   end

   assign rd_ctx = ctx_q[rd_idx];
endmodule

// File: rtl/sag_term.sv
module sag_term
   import sag_pkg::*;
#(
   parameter int CNT_N     = 8,
   parameter int CNT_W     = 16,
   parameter int ZERO_SLOT = 7,
   parameter int UNR_W     = 4
) (
   input  logic [CNT_N*CNT_W-1:0] cnt_flat,
   input  logic [SLOT_W-1:0]      slot_a,
   input  logic [SLOT_W-1:0]      slot_b,
   input  logic [SHAMT_W-1:0]     sh_a,
   input  logic [SHAMT_W-1:0]     sh_b,
   input  logic [UNR_W-1:0]       unroll,
   input  logic                   use_unroll,
   output logic [CNT_W-1:0]       term
);
   logic [CNT_W-1:0] bank [CNT_N];
   logic [CNT_W-1:0] val_a, val_b, op_a;

   for (genvar k = 0; k < CNT_N; k++) begin : g_slot
      if (k == ZERO_SLOT) begin : g_zero
         assign bank[k] = '0;
      end else begin : g_live
         assign bank[k] = cnt_flat[k*CNT_W +: CNT_W];
      end
   end

   assign val_a = bank[slot_a];
   assign val_b = bank[slot_b];
   assign op_a  = use_unroll ? {{(CNT_W-UNR_W){1'b0}}, unroll} : val_a;
   assign term  = (op_a << sh_a) | (val_b << sh_b);

   // R5: the reserved slot contributes nothing
   always_comb begin
      if (slot_b == SLOT_W'(ZERO_SLOT))
         a_zero_slot_r5: assert (val_b == '0);
   end
endmodule

// File: rtl/sag_top.sv
module sag_top
   import sag_pkg::*;
#(
   parameter int NUM_CTX   = 4,
   parameter int CNT_N     = 8,
   parameter int CNT_W     = 16,
   parameter int ADDR_W    = 16,
   parameter int ZERO_SLOT = 7,
   parameter int UNR_W     = 4,
   localparam int IDX_W    = (NUM_CTX > 1) ? $clog2(NUM_CTX) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [IDX_W-1:0]       wr_idx,
   input  logic [WORD_W-1:0]      wr_word,
   input  logic                   req_valid,
   input  logic [IDX_W-1:0]       req_ctx,
   input  logic [UNR_W-1:0]       req_unroll,
   input  logic                   req_use_unroll,
   input  logic                   req_use_alu,
   input  logic [ADDR_W-1:0]      req_alu_addr,
   input  logic [CNT_N*CNT_W-1:0] loop_cnt,
   output logic                   addr_valid,
   output logic [ADDR_W-1:0]      addr_out
);
   if (ADDR_W != BASE_W || CNT_W != ADDR_W) begin : g_bad_width
      $error("sag_top: address and counter widths must match the descriptor base width");
   end
   if (CNT_N > (1 << SLOT_W) || ZERO_SLOT >= CNT_N) begin : g_bad_slots
      $error("sag_top: counter bank does not fit the descriptor slot fields");
   end
   if (UNR_W > CNT_W) begin : g_bad_unroll
      $error("sag_top: unroll field wider than a counter");
   end

   sag_ctx_t         cur_ctx;
   logic [CNT_W-1:0] term_d;

   sag_ctx_rf #(.NUM_CTX(NUM_CTX)) u_rf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_idx  (wr_idx),
      .wr_word (wr_word),
      .rd_idx  (req_ctx),
      .rd_ctx  (cur_ctx)
   );

   sag_term #(
      .CNT_N(CNT_N), .CNT_W(CNT_W), .ZERO_SLOT(ZERO_SLOT), .UNR_W(UNR_W)
   ) u_term (
      .cnt_flat   (loop_cnt),
      .slot_a     (cur_ctx.slot_a),
      .slot_b     (cur_ctx.slot_b),
      .sh_a       (cur_ctx.sh_a),
      .sh_b       (cur_ctx.sh_b),
      .unroll     (req_unroll),
      .use_unroll (req_use_unroll),
      .term       (term_d)
   );

   logic              vld_q;
   logic              byp_q;
   logic [ADDR_W-1:0] base_q;
   logic [CNT_W-1:0]  term_q;
   logic [ADDR_W-1:0] alu_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         byp_q  <= 1'b0;
         base_q <= '0;
         term_q <= '0;
         alu_q  <= '0;
      end else begin
         vld_q <= req_valid;
         if (req_valid) begin
            byp_q  <= req_use_alu;
            base_q <= cur_ctx.base;
            term_q <= term_d;
            alu_q  <= req_alu_addr;
         end
      end
   end

   assign addr_valid = vld_q;
   assign addr_out   = byp_q ? alu_q : ADDR_W'(base_q + term_q);

   // R8: valid output trails the request by one cycle
   p_valid_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> addr_valid);
   p_idle_lag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !addr_valid);

   // R7: pass-through address reproduced one cycle later
   p_alu_bypass_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_use_alu) |=> (addr_out == $past(req_alu_addr)));
endmodule

// File: tb/sag_top_tb.sv
`timescale 1ns/1ps
module sag_top_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         wr_en = 1'b0;
   logic [1:0]   wr_idx = '0;
   logic [31:0]  wr_word = '0;
   logic         req_valid = 1'b0;
   logic [1:0]   req_ctx = '0;
   logic [3:0]   req_unroll = '0;
   logic         req_use_unroll = 1'b0;
   logic         req_use_alu = 1'b0;
   logic [15:0]  req_alu_addr = '0;
   logic [127:0] loop_cnt = '0;
   logic         addr_valid;
   logic [15:0]  addr_out;

   always #5 clk = ~clk;

   sag_top u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word),
      .req_valid(req_valid), .req_ctx(req_ctx), .req_unroll(req_unroll),
      .req_use_unroll(req_use_unroll), .req_use_alu(req_use_alu),
      .req_alu_addr(req_alu_addr), .loop_cnt(loop_cnt),
      .addr_valid(addr_valid), .addr_out(addr_out)
   );

   typedef struct {
      bit          vld;
      logic [15:0] addr;
      string       tag;
   } exp_t;

   exp_t        sb[$];
   logic [31:0] shadow [4];
   logic [15:0] cnt [8];
   int          n_vec = 0;
   int          n_bad = 0;
   bit          mon_on = 1'b0;
   bit          done = 1'b0;

   function automatic logic [15:0] model(logic [31:0] w, logic [3:0] un, bit uu,
                                         bit ua, logic [15:0] aa);
      logic [15:0] a, b, t;
      a = uu ? {12'h000, un} : ((w[26:24] == 3'd7) ? 16'h0 : cnt[w[26:24]]);
      b = (w[29:27] == 3'd7) ? 16'h0 : cnt[w[29:27]];
      t = (a << w[19:16]) | (b << w[23:20]);
      return ua ? aa : 16'(w[15:0] + t);
   endfunction

   function automatic logic [31:0] mk(logic [15:0] base, logic [3:0] sa, logic [3:0] sb_,
                                      logic [2:0] ia, logic [2:0] ib);
      return {2'b00, ib, ia, sb_, sa, base};
   endfunction

   task automatic step(bit we, logic [1:0] wi, logic [31:0] wd, bit rv, logic [1:0] rc,
                       logic [3:0] un, bit uu, bit ua, logic [15:0] aa, string tag);
      exp_t e;
      @(negedge clk);
      for (int k = 0; k < 8; k++) loop_cnt[k*16 +: 16] = cnt[k];
      wr_en = we; wr_idx = wi; wr_word = wd;
      req_valid = rv; req_ctx = rc; req_unroll = un;
      req_use_unroll = uu; req_use_alu = ua; req_alu_addr = aa;
      e.vld = rv;
      e.addr = model(shadow[rc], un, uu, ua, aa);
      e.tag = tag;
      sb.push_back(e);
      if (we) shadow[wi] = wd;
   endtask

   task automatic wr(logic [1:0] wi, logic [31:0] wd);
      step(1'b1, wi, wd, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 16'h0, "R2");
   endtask

   task automatic rq(logic [1:0] rc, string tag);
      step(1'b0, 2'd0, 32'h0, 1'b1, rc, 4'd0, 1'b0, 1'b0, 16'h0, tag);
   endtask

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   // monitor
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (mon_on && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            n_vec++;
            if (addr_valid !== e.vld) begin
               n_bad++;
               $display("FAIL %s R8 valid: actual %b expected %b", e.tag, addr_valid, e.vld);
            end else if (e.vld && addr_out !== e.addr) begin
               n_bad++;
               $display("FAIL %s addr: actual %h expected %h", e.tag, addr_out, e.addr);
            end
         end
      end
   end

   // watchdog
   initial begin
      #1_000_000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual hung expected finish");
         summary();
         $finish;
      end
   end

   initial begin
      for (int k = 0; k < 4; k++) shadow[k] = '0;
      for (int k = 0; k < 8; k++) cnt[k] = '0;
      repeat (3) @(negedge clk);
      // R1: idle during reset
      n_vec++;
      if (addr_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R1 reset: actual %b expected 0", addr_valid);
      end
      rst_n = 1'b1;
      mon_on = 1'b1;
      step(1'b0, 2'd0, 32'h0, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 16'h0, "R1");

      // R2/R3: basic 2D walk
      cnt[0] = 16'd3; cnt[1] = 16'd5; cnt[2] = 16'h0101; cnt[3] = 16'd9;
      cnt[4] = 16'd2; cnt[5] = 16'd7; cnt[6] = 16'hA5; cnt[7] = 16'hFFFF;
      wr(2'd0, mk(16'h1000, 4'd6, 4'd1, 3'd0, 3'd1));
      rq(2'd0, "R3");
      // R4: per-descriptor selection
      wr(2'd1, mk(16'h2000, 4'd4, 4'd0, 3'd3, 3'd4));
      wr(2'd2, mk(16'h0040, 4'd0, 4'd8, 3'd2, 3'd5));
      wr(2'd3, mk(16'h3333, 4'd2, 4'd3, 3'd6, 3'd0));
      rq(2'd1, "R4"); rq(2'd2, "R4"); rq(2'd3, "R4"); rq(2'd0, "R4");
      // R5: vector through zero slot, slot 7 driven all ones
      wr(2'd1, mk(16'h0500, 4'd1, 4'd9, 3'd5, 3'd7));
      rq(2'd1, "R5");
      wr(2'd2, mk(16'h0600, 4'd0, 4'd0, 3'd7, 3'd7));
      rq(2'd2, "R5");
      // R6: unroll substitution
      step(1'b0, 2'd0, 32'h0, 1'b1, 2'd0, 4'd11, 1'b1, 1'b0, 16'h0, "R6");
      step(1'b0, 2'd0, 32'h0, 1'b1, 2'd3, 4'd15, 1'b1, 1'b0, 16'h0, "R6");
      // R7: ALU pass-through
      step(1'b0, 2'd0, 32'h0, 1'b1, 2'd0, 4'd0, 1'b0, 1'b1, 16'hBEEF, "R7");
      step(1'b0, 2'd0, 32'h0, 1'b1, 2'd3, 4'd3, 1'b1, 1'b1, 16'h1234, "R7");
      // R8: gaps and back-to-back
      step(1'b0, 2'd0, 32'h0, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 16'h0, "R8");
      rq(2'd0, "R8"); rq(2'd3, "R8");
      step(1'b0, 2'd0, 32'h0, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 16'h0, "R8");
      // R9: same-cycle write and request use old contents
      step(1'b1, 2'd0, mk(16'h7000, 4'd0, 4'd0, 3'd4, 3'd7), 1'b1, 2'd0,
           4'd0, 1'b0, 1'b0, 16'h0, "R9");
      rq(2'd0, "R2");
      // R10: reserved bits ignored
      wr(2'd3, 32'hC000_0000 | mk(16'h0100, 4'd2, 4'd5, 3'd1, 3'd3));
      rq(2'd3, "R10");
      // R11: wrap
      wr(2'd2, mk(16'hFFF0, 4'd4, 4'd15, 3'd3, 3'd0));
      rq(2'd2, "R11");
      // mixed traffic
      for (int n = 0; n < 80; n++) begin
         for (int k = 0; k < 7; k++) cnt[k] = 16'($urandom);
         step(1'($urandom), 2'($urandom), $urandom, 1'($urandom), 2'($urandom),
              4'($urandom), 1'($urandom), ($urandom % 8) == 0, 16'($urandom), "R3");
      end
      step(1'b0, 2'd0, 32'h0, 1'b0, 2'd0, 4'd0, 1'b0, 1'b0, 16'h0, "R8");
      repeat (3) @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end
endmodule